// File: doc/BRIEF.md
# Letter-Serial Rotor Cipher Engine

The engine encrypts one letter at a time with an electromechanical-style rotor scheme. A letter code from 0 to 25 enters the wheel stack, crosses up to four wheels toward a fixed reflector, bounces, and comes back across the same wheels in the opposite order through their inverse wirings. Only one modulo-26 step unit exists. It is reused on every clock cycle, and a direction flag picks the forward wiring or the inverse wiring. One wheel is therefore crossed per cycle.

A load command sets three things: the wiring table for each wheel slot, the start position of each slot, and how many slots take part. The inverse wiring of every slot sits in a small writable table. This table is rebuilt from the forward wiring over 26 cycles after every load and after reset. The position counters behave like an odometer and move before each letter. Because of this, encrypting the ciphertext again from the same start positions gives back the plaintext.

Top module: `rotor_engine`

## Requirements
- R1: While reset is held, `busy` is 1, `out_valid` is 0 and `out_letter` is 0. Reset selects table s for slot s, all positions 0 and four active wheels. After reset is released, `busy` stays high for 25 more cycles while the inverse tables are built, and then falls.
- R2: A letter is accepted on a clock edge where the block is idle, `in_valid` is 1 and `load_valid` is 0. `out_valid` is then high for exactly one cycle, 2N+1 edges after the accepting edge, where N is the number of active wheels. `out_letter` keeps that result until the next completion.
- R3: Any `in_valid` or `load_valid` pulse while `busy` is 1 is ignored. It does not change the letter being processed, the wheel positions or the configuration.
- R4: Table t maps index i to (m*i+b) mod 26, with (m,b) = (3,4), (5,17), (7,9), (9,22), (11,1) for t = 0..4. Each wheel step turns code c at position p into (T[(c+p) mod 26] - p) mod 26. The forward path visits slots 0 up to N-1.
- R5: The reflector maps c to (c+13) mod 26. The return path applies the inverse of each slot's table, using the same step formula, from slot N-1 down to slot 0. The output letter never equals the input letter.
- R6: From equal start positions and configuration, feeding the ciphertext through the engine returns the plaintext.
- R7: Before each accepted letter is processed, slot 0 advances by one, wrapping 25 to 0. Slot k (k>=1) advances only when every slot below it wraps on that same letter. All four slots step, active or not.
- R8: `load_count` holds N-1, so configurations with 1 to 4 active wheels are selectable. Only slots 0..N-1 enter the computation.
- R9: A load is accepted only while idle, and it takes priority over `in_valid` in the same cycle. `load_order` holds slot s's table at bits [3s+2:3s]. `load_pos` holds slot s's position at bits [5s+4:5s]. `busy` is high for 26 cycles from the accepting edge, and no letter is processed during that time.
- R10: `out_letter` is always a legal code below 26 when `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Load configuration strobe |
| load_order | input | 12 | Table index per slot, 3 bits each |
| load_pos | input | 20 | Start position per slot, 5 bits each |
| load_count | input | 2 | Active wheel count minus one |
| in_valid | input | 1 | Letter strobe |
| in_letter | input | 5 | Plaintext letter code 0..25 |
| busy | output | 1 | High while filling tables or encrypting |
| out_valid | output | 1 | One-cycle completion strobe |
| out_letter | output | 5 | Encrypted letter code |

## Verification
The bench goes after several failure modes:
- Odometer carries: start positions of 24 and 25 on several slots make one letter roll two or three slots at once. A design that carries late, or carries from a slot that did not wrap, gives the wrong ciphertext from that letter on.
- Wheel counts of 1, 2 and 4: a wrong end-of-path index shows up as a wrong latency and a wrong letter.
- Reflector and inverse tables: round-trip decryption and the "never itself" rule would break.
- Stray strobes mid-letter: a design that listens to them while busy advances the positions or reloads the tables, and the letters that follow come out wrong.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int LETTERS = 26;
    localparam int CW      = 5;
    localparam int TW      = 3;

    typedef logic [CW-1:0] code_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_FILL = 3'd1,
        S_FWD  = 3'd2,
        S_REFL = 3'd3,
        S_BWD  = 3'd4
    } state_e;

    localparam logic [CW:0] MODV = (CW+1)'(LETTERS);

    function automatic code_t add_mod(input code_t a, input code_t b);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= MODV) s = s - MODV;
        return s[CW-1:0];
    endfunction

    function automatic code_t sub_mod(input code_t a, input code_t b);
        logic [CW:0] s;
        if (a >= b) s = {1'b0, a} - {1'b0, b};
        else        s = {1'b0, a} + MODV - {1'b0, b};
        return s[CW-1:0];
    endfunction

    // Affine wiring per table: index -> (m*index + b) mod 26
    function automatic code_t fwd_map(input logic [TW-1:0] t, input code_t i);
        int m;
        int b;
        int v;
        case (t)
            3'd1:    begin m = 5;  b = 17; end
            3'd2:    begin m = 7;  b = 9;  end
            3'd3:    begin m = 9;  b = 22; end
            3'd4:    begin m = 11; b = 1;  end
            default: begin m = 3;  b = 4;  end
        endcase
        v = (m * int'(i) + b) % LETTERS;
        return CW'(v);
    endfunction

    function automatic code_t reflect(input code_t c);
        return add_mod(c, CW'(LETTERS / 2));
    endfunction
endpackage

// File: rtl/rc_inv_ram.sv
module rc_inv_ram #(
    parameter int DEPTH = 26,
    parameter int W     = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rc_step_unit.sv
module rc_step_unit
    import rc_pkg::*;
(
    input  code_t          code_i,
    input  code_t          pos_i,
    input  logic           dir_i,     // 0 toward reflector, 1 returning
    input  logic [TW-1:0]  tbl_i,
    input  code_t          inv_i,     // inverse table word at idx_o
    output code_t          idx_o,
    output code_t          res_o
);
    code_t val;

    always_comb begin
        idx_o = add_mod(code_i, pos_i);
        val   = dir_i ? inv_i : fwd_map(tbl_i, idx_o);
        res_o = sub_mod(val, pos_i);
    end
endmodule

// File: rtl/rc_odometer.sv
module rc_odometer #(
    parameter int NW      = 4,
    parameter int CW      = 5,
    parameter int LETTERS = 26
) (
    input  logic [NW-1:0][CW-1:0] pos_i,
    output logic [NW-1:0][CW-1:0] pos_o
);
    localparam logic [CW-1:0] LAST = CW'(LETTERS - 1);

    always_comb begin
        logic carry;
        carry = 1'b1;
        for (int s = 0; s < NW; s++) begin
            pos_o[s] = pos_i[s];
            if (carry) begin
                if (pos_i[s] == LAST) begin
                    pos_o[s] = '0;
                end else begin
                    pos_o[s] = pos_i[s] + 1'b1;
                    carry    = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rotor_engine.sv
module rotor_engine
    import rc_pkg::*;
#(
    parameter int NUM_WHEELS = 4,
    localparam int SW        = $clog2(NUM_WHEELS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_valid,
    input  logic [NUM_WHEELS*TW-1:0]   load_order,
    input  logic [NUM_WHEELS*CW-1:0]   load_pos,
    input  logic [SW-1:0]              load_count,
    input  logic                       in_valid,
    input  logic [CW-1:0]              in_letter,
    output logic                       busy,
    output logic                       out_valid,
    output logic [CW-1:0]              out_letter
);
    localparam logic [CW-1:0] FILL_LAST = CW'(LETTERS - 1);

    typedef struct packed {
        state_e                          st;
        logic [CW-1:0]                   cnt;
        code_t                           cur;
        code_t                           letter;
        logic [NUM_WHEELS-1:0][TW-1:0]   order;
        logic [NUM_WHEELS-1:0][CW-1:0]   pos;
        logic [SW-1:0]                   nw;
        code_t                           out;
        logic                            done;
    } regs_t;

    regs_t r_d, r_q;

    logic [SW-1:0]                  slot;
    code_t                          step_idx;
    code_t                          step_res;
    code_t                          inv_word;
    logic [NUM_WHEELS-1:0][CW-1:0]  inv_rd;
    logic [NUM_WHEELS-1:0][CW-1:0]  pos_next;

    assign slot = r_q.cnt[SW-1:0];

    // Inverse wiring storage, one table per slot
    for (genvar g = 0; g < NUM_WHEELS; g++) begin : g_inv
        rc_inv_ram #(.DEPTH(LETTERS), .W(CW)) i_ram (
            .clk   (clk),
            .we    (r_q.st == S_FILL),
            .waddr (fwd_map(r_q.order[g], r_q.cnt)),
            .wdata (r_q.cnt),
            .raddr (step_idx),
            .rdata (inv_rd[g])
        );
    end

    assign inv_word = inv_rd[slot];

    rc_step_unit i_step (
        .code_i (r_q.cur),
        .pos_i  (r_q.pos[slot]),
        .dir_i  (r_q.st == S_BWD),
        .tbl_i  (r_q.order[slot]),
        .inv_i  (inv_word),
        .idx_o  (step_idx),
        .res_o  (step_res)
    );

    rc_odometer #(.NW(NUM_WHEELS), .CW(CW), .LETTERS(LETTERS)) i_odo (
        .pos_i (r_q.pos),
        .pos_o (pos_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_FILL: begin
                if (r_q.cnt == FILL_LAST) begin
                    r_d.st  = S_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_IDLE: begin
                if (load_valid) begin
                    r_d.order = load_order;
                    r_d.pos   = load_pos;
                    r_d.nw    = load_count;
                    r_d.cnt   = '0;
                    r_d.st    = S_FILL;
                end else if (in_valid) begin
                    r_d.letter = in_letter;
                    r_d.cur    = in_letter;
                    r_d.pos    = pos_next;
                    r_d.cnt    = '0;
                    r_d.st     = S_FWD;
                end
            end
            S_FWD: begin
                r_d.cur = step_res;
                if (slot == r_q.nw) r_d.st = S_REFL;
                else                r_d.cnt = r_q.cnt + 1'b1;
            end
            S_REFL: begin
                r_d.cur = reflect(r_q.cur);
                r_d.st  = S_BWD;
            end
            S_BWD: begin
                r_d.cur = step_res;
                if (slot == '0) begin
                    r_d.out  = step_res;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= S_FILL;
            r_q.cnt    <= '0;
            r_q.cur    <= '0;
            r_q.letter <= '0;
            for (int s = 0; s < NUM_WHEELS; s++) r_q.order[s] <= TW'(s);
            r_q.pos    <= '0;
            r_q.nw     <= SW'(NUM_WHEELS - 1);
            r_q.out    <= '0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != S_IDLE);
    assign out_valid  = r_q.done;
    assign out_letter = r_q.out;

    // Assertions
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_pos_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != S_IDLE) |=> $stable(r_q.pos));

    p_no_self_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_letter != r_q.letter));

    p_wheel0_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && in_valid && !load_valid) |=>
        (r_q.pos[0] == (($past(r_q.pos[0]) == FILL_LAST) ? '0 : $past(r_q.pos[0]) + 1'b1)));

    p_fill_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FILL && r_q.cnt == FILL_LAST) |=> !busy);

    p_out_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_letter < CW'(LETTERS)));
endmodule

// File: tb/test_rotor_engine.sv
`timescale 1ns/1ps
module test_rotor_engine;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [11:0] load_order = '0;
    logic [19:0] load_pos = '0;
    logic [1:0]  load_count = '0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_letter = '0;
    logic        busy;
    logic        out_valid;
    logic [4:0]  out_letter;

    always #10 clk = ~clk;

    rotor_engine i_rotor_engine (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid),
        .load_order(load_order), .load_pos(load_pos), .load_count(load_count),
        .in_valid(in_valid), .in_letter(in_letter),
        .busy(busy), .out_valid(out_valid), .out_letter(out_letter)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Vector table: per configuration the slot tables, slot positions, count-1
    localparam int NCFG = 6;
    localparam int VORD [NCFG][NW] = '{
        '{0,1,2,3}, '{4,2,0,1}, '{3,3,4,2}, '{1,0,4,3}, '{2,4,1,0}, '{0,0,0,0}};
    localparam int VPOS [NCFG][NW] = '{
        '{0,0,0,0}, '{24,25,25,7}, '{25,25,3,11}, '{13,2,19,25}, '{5,24,25,0}, '{20,9,1,17}};
    localparam int VCNT [NCFG] = '{3, 3, 1, 0, 2, 3};
    localparam int NTXT = 8;
    localparam int TXT [NTXT] = '{0, 25, 7, 7, 13, 4, 19, 11};

    // Reference model built from the requirement formulas
    int pm [NW];
    int mo [NW];
    int mn;

    function automatic int mfwd(input int t, input int i);
        int m; int b;
        case (t)
            1: begin m = 5;  b = 17; end
            2: begin m = 7;  b = 9;  end
            3: begin m = 9;  b = 22; end
            4: begin m = 11; b = 1;  end
            default: begin m = 3; b = 4; end
        endcase
        return (m * i + b) % 26;
    endfunction

    function automatic int minv(input int t, input int v);
        for (int i = 0; i < 26; i++) if (mfwd(t, i) == v) return i;
        return -1;
    endfunction

    function automatic int model_letter(input int x);
        int c;
        bit carry;
        carry = 1'b1;
        for (int s = 0; s < NW; s++) begin
            if (carry) begin
                if (pm[s] == 25) pm[s] = 0;
                else begin pm[s] = pm[s] + 1; carry = 1'b0; end
            end
        end
        c = x;
        for (int s = 0; s < mn; s++) c = (mfwd(mo[s], (c + pm[s]) % 26) - pm[s] + 26) % 26;
        c = (c + 13) % 26;
        for (int s = mn - 1; s >= 0; s--) c = (minv(mo[s], (c + pm[s]) % 26) - pm[s] + 26) % 26;
        return c;
    endfunction

    task automatic do_load(input int cfg, input bit with_letter);
        int k;
        @(negedge clk);
        while (busy) @(negedge clk);
        for (int s = 0; s < NW; s++) begin
            load_order[3*s +: 3] = 3'(VORD[cfg][s]);
            load_pos[5*s +: 5]   = 5'(VPOS[cfg][s]);
            mo[s] = VORD[cfg][s];
            pm[s] = VPOS[cfg][s];
        end
        load_count = 2'(VCNT[cfg]);
        mn = VCNT[cfg] + 1;
        load_valid = 1'b1;
        in_valid   = with_letter;
        in_letter  = 5'd3;
        @(negedge clk);
        load_valid = 1'b0;
        in_valid   = 1'b0;
        k = 0;
        while (busy && k < 40) begin
            chk(!out_valid, "R9", int'(out_valid), 0);
            k++;
            @(negedge clk);
        end
        chk(k == 26, "R9", k, 26);
        chk(!out_valid, "R9", int'(out_valid), 0);
    endtask

    // Sends one letter; optional stray strobes mid-flight (R3)
    task automatic send(input int x, input bit noise, input string req, output int y);
        int n2;
        int exp;
        bit early;
        @(negedge clk);
        while (busy) @(negedge clk);
        in_valid  = 1'b1;
        in_letter = 5'(x);
        @(negedge clk);
        in_valid = 1'b0;
        n2 = 2 * mn + 1;
        early = 1'b0;
        exp = model_letter(x);
        for (int k = 1; k <= n2; k++) begin
            if (noise && k == 2) begin
                in_valid = 1'b1; in_letter = 5'd9;
                load_valid = 1'b1; load_pos = 20'hFFFFF; load_order = '0; load_count = 2'd0;
            end
            @(negedge clk);
            in_valid = 1'b0; load_valid = 1'b0;
            if (k < n2 && out_valid) early = 1'b1;
        end
        chk(!early, "R2", int'(early), 0);
        chk(out_valid, "R2", int'(out_valid), 1);
        chk(out_letter == 5'(exp), req, int'(out_letter), exp);
        chk(out_letter != 5'(x), "R5", int'(out_letter), -1);
        y = int'(out_letter);
        @(negedge clk);
        chk(!out_valid, "R2", int'(out_valid), 0);
        chk(!busy && out_letter == 5'(exp), "R2", int'(out_letter), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cipher [NTXT];
        int y;
        int k;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1", int'(busy), 1);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_letter == 5'd0, "R1", int'(out_letter), 0);
        rst_n = 1'b1;
        k = 0;
        @(negedge clk);
        while (busy && k < 40) begin k++; @(negedge clk); end
        chk(k == 25, "R1", k, 25);
        // R1: reset defaults give table s per slot, positions 0, four wheels
        for (int s = 0; s < NW; s++) begin mo[s] = s; pm[s] = 0; end
        mn = 4;
        send(5, 1'b0, "R1", y);

        // Hand-worked R4/R8 case: one wheel, table 0, position 25 wraps to 0:
        // 0 -> T0[0]=4 -> reflect 17 -> inverse 13
        @(negedge clk);
        load_order = 12'd0; load_pos = 20'd25; load_count = 2'd0;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        mn = 1; mo = '{0,0,0,0}; pm = '{25,0,0,0};
        send(0, 1'b0, "R8", y);
        chk(y == 13, "R4", y, 13);

        // Vector table walk: encrypt, reload, decrypt
        for (int c = 0; c < NCFG; c++) begin
            do_load(c, 1'b0);
            for (int t = 0; t < NTXT; t++) begin
                send(TXT[t], 1'b0, (VCNT[c] == 3) ? "R7" : "R8", y);
                cipher[t] = y;
            end
            do_load(c, 1'b0);
            for (int t = 0; t < NTXT; t++) begin
                send(cipher[t], 1'b0, "R6", y);
                chk(y == TXT[t], "R6", y, TXT[t]);
            end
        end

        // R3: stray strobes during processing change nothing
        do_load(1, 1'b0);
        for (int t = 0; t < 4; t++) send(TXT[t], 1'b1, "R3", y);
        send(TXT[4], 1'b0, "R3", y);

        // R9: load and letter in the same idle cycle: load wins
        do_load(2, 1'b1);
        send(6, 1'b0, "R9", y);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule